// File: doc/BRIEF.md
# Dual-Path Synthesizer Configuration Loader

This block holds the configuration word that programs a clock synthesizer. The word has a 9-bit feedback multiplier, a 2-bit output divider code and a 2-bit test selector. It can be written in two ways. In the parallel path, dedicated pins drive the word directly while a parallel strobe is low, and the strobe's rising edge freezes it. In the serial path, a 14-bit shift register is clocked by a slow external serial clock, and a serial load strobe moves its contents into the active word. While the serial strobe is held high, the serial path is transparent.

All strobes, the serial clock, the serial data and the parallel pins are brought into the fast system clock domain through multi-stage synchronizers. Edges are detected there, so the external serial clock has to run at least four times slower than the system clock. The loaded test selector steers a TEST output to a constant low, the serial data, the feedback divider output or the half-rate output clock. A range flag reports a multiplier outside the band that locks with a 25 MHz reference.

Top module: `cfgl_loader`

## Requirements
- R1: While `par_load_n_i` is low (parallel mode), `m_o` and `n_o` follow `par_m_i` and `par_n_i`. A pin change appears on the outputs within SYNC_STAGES+1 system clocks.
- R2: On the rising edge of `par_load_n_i`, the pin values are latched. Later pin changes have no effect until `par_load_n_i` goes low again or a serial load occurs.
- R3: While `par_load_n_i` is high, each rising edge of `ser_clk_i` shifts `ser_data_i` into a 14-bit register, first bit in at the top. The frame order in time is T1, T0, an unused slot, N1, N0, then M8 down to M0.
- R4: A rising edge of `ser_load_i` copies the frame into the word: `t_o`={T1,T0}, `n_o`={N1,N0}, `m_o`=M8..M0. The unused slot's value is discarded.
- R5: While `ser_load_i` is low in serial mode, serial clock pulses shift the register but leave `m_o`, `n_o` and `t_o` unchanged.
- R6: While `ser_load_i` stays high, every serial clock rising edge updates `m_o`, `n_o` and `t_o` from the freshly shifted register contents.
- R7: Outside parallel mode, `test_o` is chosen by `t_o`: 00 gives low, 01 gives `ser_data_i`, 10 gives `mdiv_clk_i`, and 11 gives `half_clk_i`.
- R8: `test_o` is low whenever `par_load_n_i` is low, whatever the value of `t_o`.
- R9: After reset, `t_o` is 00 and `m_o`/`n_o` take the parallel pin values, even when `par_load_n_i` is high.
- R10: `m_range_err_o` is high exactly when `m_o` is below 8 or above 28.
- R11: Serial clock pulses that arrive while `par_load_n_i` is low do not alter the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| par_load_n_i | input | 1 | Parallel strobe; low selects parallel mode |
| par_m_i | input | 9 | Parallel multiplier pins |
| par_n_i | input | 2 | Parallel divider-code pins |
| ser_clk_i | input | 1 | External serial clock |
| ser_data_i | input | 1 | Serial data |
| ser_load_i | input | 1 | Serial load strobe |
| mdiv_clk_i | input | 1 | Feedback divider output, TEST source |
| half_clk_i | input | 1 | Half-rate output clock, TEST source |
| m_o | output | 9 | Active multiplier |
| n_o | output | 2 | Active divider code |
| t_o | output | 2 | Active test selector |
| test_o | output | 1 | Multiplexed test output |
| m_range_err_o | output | 1 | Multiplier outside 8..28 |

## Verification
The bench targets the unused frame slot. A decoder that is off by one slot would put a wrong bit in `n_o` or `m_o`. It also sends serial clock pulses during parallel mode; a register that kept shifting there would corrupt a frame loaded later. It checks transparency bit by bit, where a design that updates only on the strobe edge would leave the outputs stale. It checks reset with the parallel strobe high, where a design without a boot capture would come up with zero. It also drives the range flag at 7, 8, 28 and 29, where an off-by-one comparison would flag a legal value or miss an illegal one.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
    localparam int M_W     = 9;
    localparam int N_W     = 2;
    localparam int T_W     = 2;
    localparam int FRAME_W = T_W + 1 + N_W + M_W;
    localparam int NUL_POS = M_W + N_W;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
        logic [T_W-1:0] t;
    } cfg_t;

    typedef enum logic [1:0] {
        TSEL_LOW   = 2'b00,
        TSEL_SDATA = 2'b01,
        TSEL_MDIV  = 2'b10,
        TSEL_HALF  = 2'b11
    } tsel_e;

    // Slot positions: the first bit shifted in ends at the top of the register.
    function automatic cfg_t frame_to_cfg(input logic [FRAME_W-1:0] f);
        cfg_t c;
        c.m = f[M_W-1:0];
        c.n = f[NUL_POS-1:M_W];
        c.t = f[FRAME_W-1:NUL_POS+1];
        return c;
    endfunction
endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfgl_shreg.sv
module cfgl_shreg #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         din_i,
    output logic [W-1:0] next_o
);
    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (shift_i) word_d = {word_q[W-2:0], din_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign next_o = word_d;

    // R3: one shift moves every slot up by one and enters the new bit at the bottom
    a_r3_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (word_q[0] == $past(din_i)) && (word_q[W-1:1] == $past(word_q[W-2:0])));

    // R11: no shift request, no movement
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> word_q == $past(word_q));
endmodule

// File: rtl/cfgl_testsel.sv
module cfgl_testsel
    import cfgl_pkg::*;
(
    input  logic [T_W-1:0] sel_i,
    input  logic           par_mode_i,
    input  logic           sdata_i,
    input  logic           mdiv_i,
    input  logic           half_i,
    output logic           test_o
);
    always_comb begin
        test_o = 1'b0;
        if (!par_mode_i) begin
            case (tsel_e'(sel_i))
                TSEL_LOW:   test_o = 1'b0;
                TSEL_SDATA: test_o = sdata_i;
                TSEL_MDIV:  test_o = mdiv_i;
                TSEL_HALF:  test_o = half_i;
                default:    test_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cfgl_loader.sv
module cfgl_loader
    import cfgl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int M_MIN       = 8,
    parameter int M_MAX       = 28
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_load_n_i,
    input  logic [M_W-1:0] par_m_i,
    input  logic [N_W-1:0] par_n_i,
    input  logic           ser_clk_i,
    input  logic           ser_data_i,
    input  logic           ser_load_i,
    input  logic           mdiv_clk_i,
    input  logic           half_clk_i,
    output logic [M_W-1:0] m_o,
    output logic [N_W-1:0] n_o,
    output logic [T_W-1:0] t_o,
    output logic           test_o,
    output logic           m_range_err_o
);
    localparam int SYNC_W   = 4 + M_W + N_W;
    localparam int BOOT_CYC = SYNC_STAGES + 1;
    localparam int BOOT_W   = $clog2(BOOT_CYC + 1);

    typedef struct packed {
        cfg_t              cfg;
        logic              pload_q;
        logic              sload_q;
        logic              sclk_q;
        logic [BOOT_W-1:0] boot;
    } state_t;

    state_t st_d, st_q;

    logic [SYNC_W-1:0]  raw, synced;
    logic               pload_s, sload_s, sclk_s, sdata_s;
    logic [M_W-1:0]     pm_s;
    logic [N_W-1:0]     pn_s;
    logic               boot_done, pload_rise, sload_rise, sclk_rise, shift_en;
    logic [FRAME_W-1:0] sr_next;

    assign raw = {par_load_n_i, ser_load_i, ser_clk_i, ser_data_i, par_n_i, par_m_i};

    cfgl_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (synced)
    );

    assign {pload_s, sload_s, sclk_s, sdata_s, pn_s, pm_s} = synced;

    assign boot_done  = (st_q.boot == BOOT_W'(BOOT_CYC));
    assign pload_rise = pload_s & ~st_q.pload_q;
    assign sload_rise = sload_s & ~st_q.sload_q;
    assign sclk_rise  = sclk_s  & ~st_q.sclk_q;
    assign shift_en   = boot_done & pload_s & sclk_rise;

    cfgl_shreg #(.W(FRAME_W)) i_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_en),
        .din_i   (sdata_s),
        .next_o  (sr_next)
    );

    always_comb begin
        st_d         = st_q;
        st_d.pload_q = pload_s;
        st_d.sload_q = sload_s;
        st_d.sclk_q  = sclk_s;
        if (!boot_done) begin
            st_d.boot  = st_q.boot + BOOT_W'(1);
            st_d.cfg.m = pm_s;
            st_d.cfg.n = pn_s;
            st_d.cfg.t = '0;
        end else if (!pload_s || pload_rise) begin
            st_d.cfg.m = pm_s;
            st_d.cfg.n = pn_s;
        end else if (sload_rise || (sload_s && sclk_rise)) begin
            st_d.cfg = frame_to_cfg(sr_next);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cfgl_testsel i_testsel (
        .sel_i      (st_q.cfg.t),
        .par_mode_i (~pload_s),
        .sdata_i    (sdata_s),
        .mdiv_i     (mdiv_clk_i),
        .half_i     (half_clk_i),
        .test_o     (test_o)
    );

    assign m_o = st_q.cfg.m;
    assign n_o = st_q.cfg.n;
    assign t_o = st_q.cfg.t;
    assign m_range_err_o = (st_q.cfg.m < M_W'(M_MIN)) || (st_q.cfg.m > M_W'(M_MAX));

    // R1: parallel mode tracks the synchronized pins one cycle later
    a_r1_par_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_done && !pload_s) |=> (m_o == $past(pm_s)) && (n_o == $past(pn_s)));

    // R5: serial mode with the strobe low and no parallel latch keeps the word
    a_r5_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_done && pload_s && !pload_rise && !sload_s) |=> (st_q.cfg == $past(st_q.cfg)));

    // R6: transparent serial path follows the shifted frame
    a_r6_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_done && pload_s && !pload_rise && sload_s && sclk_rise)
            |=> (m_o == $past(sr_next[M_W-1:0])));

    // R8: no test activity in parallel mode
    a_r8_test_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pload_s |-> !test_o);

    // R9: boot window leaves the test selector cleared
    a_r9_boot_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_done |=> (t_o == '0));
endmodule

// File: tb/test_cfgl_loader.sv
module test_cfgl_loader;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       par_load_n_i, ser_clk_i, ser_data_i, ser_load_i, mdiv_clk_i, half_clk_i;
    logic [8:0] par_m_i;
    logic [1:0] par_n_i;
    logic [8:0] m_o;
    logic [1:0] n_o, t_o;
    logic       test_o, m_range_err_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [13:0] sr_model = '0;
    logic [8:0]  exp_m;
    logic [1:0]  exp_n, exp_t;

    always #2 clk = ~clk;

    cfgl_loader i_cfgl_loader (
        .clk(clk), .rst_n(rst_n), .par_load_n_i(par_load_n_i), .par_m_i(par_m_i),
        .par_n_i(par_n_i), .ser_clk_i(ser_clk_i), .ser_data_i(ser_data_i),
        .ser_load_i(ser_load_i), .mdiv_clk_i(mdiv_clk_i), .half_clk_i(half_clk_i),
        .m_o(m_o), .n_o(n_o), .t_o(t_o), .test_o(test_o), .m_range_err_o(m_range_err_o)
    );

    function automatic logic [13:0] mk_frame(logic [1:0] t, logic nul, logic [1:0] n, logic [8:0] m);
        return {t, nul, n, m};
    endfunction

    function automatic logic exp_err(logic [8:0] m);
        return (m < 9'd8) || (m > 9'd28);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_word(string req);
        check(req, m_o, exp_m);
        check(req, n_o, exp_n);
        check(req, t_o, exp_t);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_pulse(logic d);
        ser_data_i = d;
        wait_cyc(4);
        ser_clk_i = 1'b1;
        if (par_load_n_i) begin
            sr_model = {sr_model[12:0], d};
            if (ser_load_i) {exp_t, exp_n, exp_m} = {sr_model[13:12], sr_model[10:9], sr_model[8:0]};
        end
        wait_cyc(4);
        ser_clk_i = 1'b0;
        wait_cyc(4);
    endtask

    task automatic send_frame(logic [13:0] f);
        for (int i = 13; i >= 0; i--) sclk_pulse(f[i]);
    endtask

    task automatic sload_pulse();
        ser_load_i = 1'b1;
        if (par_load_n_i) {exp_t, exp_n, exp_m} = {sr_model[13:12], sr_model[10:9], sr_model[8:0]};
        wait_cyc(6);
        ser_load_i = 1'b0;
        wait_cyc(6);
    endtask

    task automatic par_write(logic [8:0] m, logic [1:0] n);
        par_load_n_i = 1'b0;
        par_m_i = m;
        par_n_i = n;
        exp_m = m;
        exp_n = n;
        wait_cyc(6);
        par_load_n_i = 1'b1;
        wait_cyc(6);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [13:0] f;
        void'($urandom(32'd5171));
        rst_n = 1'b0; par_load_n_i = 1'b1; par_m_i = 9'd25; par_n_i = 2'd2;
        ser_clk_i = 1'b0; ser_data_i = 1'b0; ser_load_i = 1'b0;
        mdiv_clk_i = 1'b0; half_clk_i = 1'b0;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(8);
        exp_m = 9'd25; exp_n = 2'd2; exp_t = 2'd0;
        check_word("R9 reset word");
        check("R9 reset test", test_o, 0);
        check("R10 reset flag", m_range_err_o, 0);

        // R2: pins ignored once strobe high
        par_m_i = 9'd10; par_n_i = 2'd0;
        wait_cyc(8);
        check_word("R2 pins ignored after boot");

        // R3/R4: frame with unused slot set
        send_frame(mk_frame(2'b00, 1'b1, 2'd1, 9'd9));
        sload_pulse();
        check("R4 m", m_o, 9); check("R4 n", n_o, 1); check("R3 t", t_o, 0);

        // R5: shifting with strobe low leaves word alone
        for (int i = 0; i < 5; i++) sclk_pulse(1'($urandom));
        check_word("R5 hold while shifting");

        // R7: test selector sources
        send_frame(mk_frame(2'b11, 1'b0, 2'd0, 9'd20)); sload_pulse();
        check_word("R4 t=11 load");
        half_clk_i = 1'b1; wait_cyc(2); check("R7 half hi", test_o, 1);
        half_clk_i = 1'b0; wait_cyc(2); check("R7 half lo", test_o, 0);
        send_frame(mk_frame(2'b10, 1'b0, 2'd3, 9'd12)); sload_pulse();
        mdiv_clk_i = 1'b1; wait_cyc(2); check("R7 mdiv hi", test_o, 1);
        mdiv_clk_i = 1'b0; wait_cyc(2); check("R7 mdiv lo", test_o, 0);
        send_frame(mk_frame(2'b01, 1'b1, 2'd2, 9'd15)); sload_pulse();
        ser_data_i = 1'b1; wait_cyc(6); check("R7 sdata hi", test_o, 1);
        ser_data_i = 1'b0; wait_cyc(6); check("R7 sdata lo", test_o, 0);
        send_frame(mk_frame(2'b00, 1'b0, 2'd2, 9'd15)); sload_pulse();
        mdiv_clk_i = 1'b1; half_clk_i = 1'b1; ser_data_i = 1'b1; wait_cyc(6);
        check("R7 low select", test_o, 0);
        ser_data_i = 1'b0;

        // R8/R1/R2: parallel mode with t=11 loaded
        send_frame(mk_frame(2'b11, 1'b0, 2'd1, 9'd22)); sload_pulse();
        par_load_n_i = 1'b0; par_m_i = 9'd17; par_n_i = 2'd3; wait_cyc(6);
        check("R8 test low in parallel", test_o, 0);
        exp_m = 9'd17; exp_n = 2'd3;
        check_word("R1 follow a");
        par_m_i = 9'd12; par_n_i = 2'd1; wait_cyc(6);
        exp_m = 9'd12; exp_n = 2'd1;
        check_word("R1 follow b");
        par_load_n_i = 1'b1; wait_cyc(6);
        par_m_i = 9'd30; par_n_i = 2'd0; wait_cyc(6);
        check_word("R2 latched");
        mdiv_clk_i = 1'b0; half_clk_i = 1'b0;

        // R11: pulses during parallel mode do not shift
        f = mk_frame(2'b10, 1'b1, 2'd2, 9'd27);
        send_frame(f);
        par_load_n_i = 1'b0; wait_cyc(6);
        for (int i = 0; i < 5; i++) sclk_pulse(1'b1);
        par_load_n_i = 1'b1; wait_cyc(6);
        sload_pulse();
        check("R11 m", m_o, 27); check("R11 n", n_o, 2); check("R11 t", t_o, 2);

        // R6: transparent mode, bit by bit
        ser_load_i = 1'b1; wait_cyc(6);
        check_word("R6 strobe rise");
        f = mk_frame(2'b01, 1'b0, 2'd3, 9'($urandom));
        for (int i = 13; i >= 0; i--) begin
            sclk_pulse(f[i]);
            check_word("R6 transparent step");
        end
        ser_load_i = 1'b0; wait_cyc(6);
        for (int i = 0; i < 3; i++) sclk_pulse(1'b1);
        check_word("R5 hold after strobe fall");

        // R10: range boundaries
        par_write(9'd7, 2'd0);  check("R10 m=7", m_range_err_o, 1);
        par_write(9'd8, 2'd0);  check("R10 m=8", m_range_err_o, 0);
        par_write(9'd28, 2'd0); check("R10 m=28", m_range_err_o, 0);
        par_write(9'd29, 2'd0); check("R10 m=29", m_range_err_o, 1);
        par_write(9'd511, 2'd0); check("R10 m=511", m_range_err_o, 1);

        // mixed random traffic
        for (int it = 0; it < 40; it++) begin
            if ($urandom % 3 == 0) begin
                par_write(9'($urandom), 2'($urandom));
                check_word("R2 random parallel");
            end else begin
                send_frame(mk_frame(2'($urandom), 1'($urandom), 2'($urandom), 9'($urandom % 40)));
                sload_pulse();
                check_word("R4 random serial");
            end
            check("R10 random flag", m_range_err_o, exp_err(exp_m));
        end

        done = 1'b1;
        report();
        $finish;
    end
endmodule